// File: doc/BRIEF.md
# Shadowed-Seconds Real-Time Clock Peripheral

This block is a real-time clock reached over a simple register bus. A slow-clock tick enable, nominally a 32 kHz timebase, is divided down to a millisecond tick. The block keeps a millisecond counter and a seconds counter. Software does not read the live counters. Once every eight slow ticks the block copies both counters to a bus-side pair. During the slow-tick interval that ends in that copy, a busy flag is raised. Writes issued while busy is high are discarded. Reads are always allowed.

Reading the milliseconds register loads the bus-side seconds into a shadow register in the same access. A later read of the shadow register therefore gives a seconds value that matches the milliseconds already read. Two seconds-compare alarms set write-one-to-clear status bits. An alarm value of zero turns its alarm off. A per-source mask selects which status bits drive the single active-high interrupt line. The millisecond alarm and the two countdown sources are present only as storage and as mask and status bit positions. They never fire.

Top module: `rtc_shadow`

## Requirements
- R1: After synchronous reset, every readable register reads 0 and `irq` is low.
- R2: The millisecond count advances once every `TICKS_PER_MS` slow ticks and runs from 0 to `MS_PER_SEC-1`. When it wraps back to 0, seconds increments modulo 2^`SEC_W`.
- R3: Bit 0 at offset 0x04 is 1 exactly while the slow-tick phase is the last of eight. At the tick that ends that phase, the values at 0x08 (seconds) and 0x10 (milliseconds) take the live counter values from before that tick. At all other times they hold.
- R4: A bus read of 0x10 loads the seconds value currently visible at 0x08 into the shadow register at 0x0C.
- R5: A bus write issued while the busy bit is 1 changes no register.
- R6: A write to 0x08 outside busy loads the live seconds counter. The new value appears at 0x08 after the next copy.
- R7: Alarm registers at 0x14 (alarm 0) and 0x18 (alarm 1) read back as written. A non-zero alarm sets status bit 0 or bit 1 on the millisecond wrap whose incremented seconds equals it.
- R8: An alarm register holding 0 never sets its status bit, not even when seconds wraps to 0.
- R9: Writing 1 to a bit of the status register at 0x2C clears that bit. Writing 0 leaves it unchanged.
- R10: The mask register at 0x28 holds bits [4:0]. `irq` is high exactly when some status bit and its mask bit are both 1.
- R11: The millisecond alarm at 0x1C reads back as written, and mask bits 2 to 4 are storable. Status bits 2 to 4 (millisecond alarm, seconds countdown, millisecond countdown) always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle slow-clock tick enable |
| bus_rd | input | 1 | Read strobe (side effect on 0x10) |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Active-high interrupt |

## Verification
The bench steps the slow tick one interval at a time and compares every visible register against an arithmetic model of phase, prescaler and counters. A design that reported live counters instead of the copies would show the millisecond value moving between copy points. One that loaded the shadow from the live seconds would pair a seconds value with a stale millisecond value. Writes are aimed at the busy phase to catch a design that lets them through. Seconds is forced through its wrap to 0 with zeroed alarms, which exposes a design that compares against a zero alarm. The status clears use a mix of one and zero bits, with only one source unmasked, so a design that cleared on any write or ignored the mask would drive `irq` wrongly.

// File: rtl/rtc_shadow_pkg.sv
package rtc_shadow_pkg;

    localparam int ADDR_W   = 6;
    localparam int DATA_W   = 32;
    localparam int NUM_SRC  = 5;
    localparam int NUM_SALM = 2;

    // Register byte offsets
    localparam logic [ADDR_W-1:0] OFS_BUSY   = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_SEC    = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_SHADOW = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_MS     = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_ALM0   = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_ALM1   = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_MSALM  = 6'h1C;
    localparam logic [ADDR_W-1:0] OFS_MASK   = 6'h28;
    localparam logic [ADDR_W-1:0] OFS_STAT   = 6'h2C;

    // Interrupt source bit positions
    localparam int SRC_SALM0  = 0;
    localparam int SRC_SALM1  = 1;
    localparam int SRC_MSALM  = 2;
    localparam int SRC_SCDN   = 3;
    localparam int SRC_MSCDN  = 4;

    // Decoded, busy-qualified write strobes
    typedef struct packed {
        logic sec;
        logic alm0;
        logic alm1;
        logic msalm;
        logic mask;
        logic stat;
    } wr_sel_t;

    function automatic wr_sel_t decode_wr(logic en, logic [ADDR_W-1:0] a);
        wr_sel_t s;
        s.sec   = en && (a == OFS_SEC);
        s.alm0  = en && (a == OFS_ALM0);
        s.alm1  = en && (a == OFS_ALM1);
        s.msalm = en && (a == OFS_MSALM);
        s.mask  = en && (a == OFS_MASK);
        s.stat  = en && (a == OFS_STAT);
        return s;
    endfunction

    function automatic logic any_pending(logic [NUM_SRC-1:0] st,
                                         logic [NUM_SRC-1:0] mk);
        return |(st & mk);
    endfunction

endpackage

// File: rtl/rtc_shadow_timebase.sv
module rtc_shadow_timebase #(
    parameter int TICKS_PER_MS = 32,
    parameter int COPY_TICKS   = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_en,
    output logic busy,
    output logic copy_stb,
    output logic ms_tick
);
    localparam int PH_W  = (COPY_TICKS > 1) ? $clog2(COPY_TICKS) : 1;
    localparam int PRE_W = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
    localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(COPY_TICKS - 1);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICKS_PER_MS - 1);

    logic [PH_W-1:0]  phase;
    logic [PRE_W-1:0] pre;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
            pre   <= '0;
        end else if (tick_en) begin
            phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
            pre   <= (pre == PRE_LAST) ? '0 : pre + 1'b1;
        end
    end

    always_comb begin
        busy     = (phase == PH_LAST);
        copy_stb = tick_en && busy;
        ms_tick  = tick_en && (pre == PRE_LAST);
    end

    // busy lasts exactly one slow-tick interval
    AST_BUSY_ONE_INTERVAL: assert property (@(posedge clk) disable iff (rst)
        (busy && tick_en) |=> !busy) else $error("busy held past its tick"); // R3

endmodule

// File: rtl/rtc_shadow_counter.sv
module rtc_shadow_counter #(
    parameter int MS_PER_SEC = 1000,
    parameter int SEC_W      = 32
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           ms_tick,
    input  logic                           copy_stb,
    input  logic                           sec_wr,
    input  logic [SEC_W-1:0]               sec_wdata,
    output logic [SEC_W-1:0]               bus_sec,
    output logic [$clog2(MS_PER_SEC)-1:0]  bus_ms,
    output logic                           rollover,
    output logic [SEC_W-1:0]               sec_next
);
    localparam int MS_W = $clog2(MS_PER_SEC);
    localparam logic [MS_W-1:0] MS_LAST = MS_W'(MS_PER_SEC - 1);

    logic [MS_W-1:0]  ms;
    logic [SEC_W-1:0] sec;
    logic             ms_last;

    always_comb begin
        ms_last  = (ms == MS_LAST);
        rollover = ms_tick && ms_last;
        sec_next = sec + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ms      <= '0;
            sec     <= '0;
            bus_ms  <= '0;
            bus_sec <= '0;
        end else begin
            if (ms_tick)
                ms <= ms_last ? '0 : ms + 1'b1;
            if (sec_wr)
                sec <= sec_wdata;
            else if (rollover)
                sec <= sec_next;
            if (copy_stb) begin
                bus_sec <= sec;
                bus_ms  <= ms;
            end
        end
    end

    AST_MS_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        ms <= MS_LAST) else $error("millisecond count out of range"); // R2

    AST_BUS_COPY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !copy_stb |=> ($stable(bus_sec) && $stable(bus_ms))) else $error("bus copy moved"); // R3

endmodule

// File: rtl/rtc_shadow_alarm.sv
module rtc_shadow_alarm
    import rtc_shadow_pkg::*;
#(
    parameter int SEC_W = 32,
    parameter int MS_W  = 10
) (
    input  logic                        clk,
    input  logic                        rst,
    input  wr_sel_t                     wsel,
    input  logic [DATA_W-1:0]           wdata,
    input  logic                        rollover,
    input  logic [SEC_W-1:0]            sec_next,
    output logic [NUM_SALM-1:0][SEC_W-1:0] salm,
    output logic [MS_W-1:0]             msalm,
    output logic [NUM_SRC-1:0]          mask,
    output logic [NUM_SRC-1:0]          status,
    output logic                        irq
);
    logic [NUM_SALM-1:0] hit;
    logic [NUM_SALM-1:0] salm_wr;
    logic [NUM_SRC-1:0]  set_v;
    logic [NUM_SRC-1:0]  clr_v;

    assign salm_wr = {wsel.alm1, wsel.alm0};

    // One comparator per seconds alarm; zero means off
    for (genvar g = 0; g < NUM_SALM; g++) begin : g_cmp
        assign hit[g] = rollover && (salm[g] != '0) && (sec_next == salm[g]);
    end

    always_comb begin
        set_v = '0;
        set_v[SRC_SALM0] = hit[0];
        set_v[SRC_SALM1] = hit[1];
        clr_v = wsel.stat ? wdata[NUM_SRC-1:0] : '0;
        irq   = any_pending(status, mask);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            salm   <= '0;
            msalm  <= '0;
            mask   <= '0;
            status <= '0;
        end else begin
            for (int i = 0; i < NUM_SALM; i++)
                if (salm_wr[i])
                    salm[i] <= wdata[SEC_W-1:0];
            if (wsel.msalm)
                msalm <= wdata[MS_W-1:0];
            if (wsel.mask)
                mask <= wdata[NUM_SRC-1:0];
            status <= (status & ~clr_v) | set_v;
        end
    end

    AST_ZERO_ALARM_SILENT: assert property (@(posedge clk) disable iff (rst)
        (salm[0] == '0 && !wsel.alm0 && !wsel.stat) |=> (status[SRC_SALM0] == $past(status[SRC_SALM0])))
        else $error("zero alarm fired"); // R8

    AST_STUB_NEVER_SET: assert property (@(posedge clk) disable iff (rst)
        status[SRC_MSCDN:SRC_MSALM] == '0) else $error("stub source set"); // R11

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (wsel.stat && wdata[SRC_SALM1] && !hit[1]) |=> !status[SRC_SALM1]) else $error("status not cleared"); // R9

endmodule

// File: rtl/rtc_shadow.sv
module rtc_shadow
    import rtc_shadow_pkg::*;
#(
    parameter int TICKS_PER_MS = 32,
    parameter int MS_PER_SEC   = 1000,
    parameter int SEC_W        = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_en,
    input  logic        bus_rd,
    input  logic        bus_wr,
    input  logic [5:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq
);
    localparam int MS_W = $clog2(MS_PER_SEC);

    logic                 busy, copy_stb, ms_tick;
    logic [SEC_W-1:0]     bus_sec, sec_next, shadow;
    logic [MS_W-1:0]      bus_ms, msalm;
    logic                 rollover;
    logic [NUM_SALM-1:0][SEC_W-1:0] salm;
    logic [NUM_SRC-1:0]   mask, status;
    wr_sel_t              wsel;

    assign wsel = decode_wr(bus_wr && !busy, bus_addr);

    rtc_shadow_timebase #(
        .TICKS_PER_MS (TICKS_PER_MS),
        .COPY_TICKS   (8)
    ) u_tb (
        .clk      (clk),
        .rst      (rst),
        .tick_en  (tick_en),
        .busy     (busy),
        .copy_stb (copy_stb),
        .ms_tick  (ms_tick)
    );

    rtc_shadow_counter #(
        .MS_PER_SEC (MS_PER_SEC),
        .SEC_W      (SEC_W)
    ) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .ms_tick   (ms_tick),
        .copy_stb  (copy_stb),
        .sec_wr    (wsel.sec),
        .sec_wdata (bus_wdata[SEC_W-1:0]),
        .bus_sec   (bus_sec),
        .bus_ms    (bus_ms),
        .rollover  (rollover),
        .sec_next  (sec_next)
    );

    rtc_shadow_alarm #(
        .SEC_W (SEC_W),
        .MS_W  (MS_W)
    ) u_alm (
        .clk      (clk),
        .rst      (rst),
        .wsel     (wsel),
        .wdata    (bus_wdata),
        .rollover (rollover),
        .sec_next (sec_next),
        .salm     (salm),
        .msalm    (msalm),
        .mask     (mask),
        .status   (status),
        .irq      (irq)
    );

    // Shadow seconds: loaded by a milliseconds read
    always_ff @(posedge clk) begin
        if (rst)
            shadow <= '0;
        else if (bus_rd && bus_addr == OFS_MS)
            shadow <= bus_sec;
    end

    always_comb begin
        case (bus_addr)
            OFS_BUSY:   bus_rdata = {31'd0, busy};
            OFS_SEC:    bus_rdata = 32'(bus_sec);
            OFS_SHADOW: bus_rdata = 32'(shadow);
            OFS_MS:     bus_rdata = 32'(bus_ms);
            OFS_ALM0:   bus_rdata = 32'(salm[0]);
            OFS_ALM1:   bus_rdata = 32'(salm[1]);
            OFS_MSALM:  bus_rdata = 32'(msalm);
            OFS_MASK:   bus_rdata = 32'(mask);
            OFS_STAT:   bus_rdata = 32'(status);
            default:    bus_rdata = 32'd0;
        endcase
    end

    AST_SHADOW_LOADS: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == OFS_MS) |=> (shadow == $past(bus_sec))) else $error("shadow not loaded"); // R4

    AST_BUSY_DROPS_MASK: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && busy && bus_addr == OFS_MASK) |=> $stable(mask)) else $error("busy write landed"); // R5

endmodule

// File: tb/rtc_shadow_test.sv
module rtc_shadow_test;
    localparam int TPM = 2;
    localparam int MPS = 5;
    localparam int SW  = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model state
    int m_phase = 0, m_pre = 0, m_ms = 0, m_sec = 0;
    int m_bsec = 0, m_bms = 0, m_shadow = 0;
    int m_a0 = 0, m_a1 = 0, m_msa = 0, m_mask = 0, m_stat = 0;

    always #2 clk = ~clk;

    rtc_shadow #(.TICKS_PER_MS(TPM), .MS_PER_SEC(MPS), .SEC_W(SW)) uut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic rd(input logic [5:0] a, output int v);
        bus_rd = 1'b1; bus_addr = a;
        #1 v = int'(bus_rdata);
        @(negedge clk);
        bus_rd = 1'b0;
        if (a == 6'h10) m_shadow = m_bsec;
    endtask

    task automatic wr(input logic [5:0] a, input int v);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
        if (m_phase != 7) begin
            case (a)
                6'h08: m_sec = v % 256;
                6'h14: m_a0 = v % 256;
                6'h18: m_a1 = v % 256;
                6'h1C: m_msa = v % 8;
                6'h28: m_mask = v % 32;
                6'h2C: m_stat = m_stat & ~(v % 32);
                default: ;
            endcase
        end
    endtask

    task automatic tick();
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
        if (m_phase == 7) begin m_bsec = m_sec; m_bms = m_ms; end
        m_phase = (m_phase + 1) % 8;
        m_pre++;
        if (m_pre == TPM) begin
            m_pre = 0;
            if (m_ms == MPS - 1) begin
                m_ms = 0;
                m_sec = (m_sec + 1) % 256;
                if (m_a0 != 0 && m_sec == m_a0) m_stat |= 1;
                if (m_a1 != 0 && m_sec == m_a1) m_stat |= 2;
            end else m_ms++;
        end
    endtask

    function automatic int exp_irq();
        return ((m_stat & m_mask) != 0) ? 1 : 0;
    endfunction

    task automatic to_idle();
        if (m_phase == 7) tick();
    endtask

    task automatic observe(string tag);
        int v;
        rd(6'h04, v); check({tag, " R3 busy"}, v, (m_phase == 7) ? 1 : 0);
        rd(6'h10, v); check({tag, " R2 ms"}, v, m_bms);
        rd(6'h0C, v); check({tag, " R4 shadow"}, v, m_shadow);
        rd(6'h08, v); check({tag, " R3 sec"}, v, m_bsec);
        rd(6'h2C, v); check({tag, " R7 status"}, v, m_stat);
        #1 check({tag, " R10 irq"}, int'(irq), exp_irq());
    endtask

    initial begin
        int v;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1: reset values
        foreach (uut.bus_rdata[i]) ; // no-op
        rd(6'h04, v); check("R1 busy", v, 0);
        rd(6'h08, v); check("R1 sec", v, 0);
        rd(6'h0C, v); check("R1 shadow", v, 0);
        rd(6'h10, v); check("R1 ms", v, 0);
        rd(6'h14, v); check("R1 alm0", v, 0);
        rd(6'h18, v); check("R1 alm1", v, 0);
        rd(6'h1C, v); check("R1 msalm", v, 0);
        rd(6'h28, v); check("R1 mask", v, 0);
        rd(6'h2C, v); check("R1 status", v, 0);
        #1 check("R1 irq", int'(irq), 0);

        // R2 R3 R4: sweep every tick
        for (int i = 0; i < 100; i++) begin tick(); observe("sweep"); end

        // R6 R8: load near wrap, zero alarms, cross 255 -> 0
        to_idle();
        wr(6'h08, 250);
        for (int i = 0; i < 80; i++) begin
            tick(); observe("R6 R8 wrap");
        end

        // R5: writes during busy are dropped
        while (m_phase != 7) tick();
        wr(6'h28, 31);
        wr(6'h14, 5);
        wr(6'h08, 77);
        rd(6'h28, v); check("R5 mask", v, 0);
        rd(6'h14, v); check("R5 alm0", v, 0);
        for (int i = 0; i < 20; i++) begin tick(); observe("R5 after"); end

        // R7 R10: alarm1 unmasked-off, alarm0 masked-on
        to_idle();
        wr(6'h14, (m_sec + 3) % 256);
        wr(6'h18, (m_sec + 1) % 256);
        wr(6'h28, 1);
        rd(6'h14, v); check("R7 alm0 readback", v, m_a0);
        rd(6'h18, v); check("R7 alm1 readback", v, m_a1);
        for (int i = 0; i < 40; i++) begin tick(); observe("R7 alarm"); end
        check("R7 both fired", m_stat, 3);

        // R9: write-one-to-clear
        to_idle();
        wr(6'h2C, 0);
        rd(6'h2C, v); check("R9 zero write", v, 3);
        wr(6'h2C, 2);
        rd(6'h2C, v); check("R9 clear bit1", v, 1);
        #1 check("R10 irq still", int'(irq), 1);
        wr(6'h2C, 1);
        rd(6'h2C, v); check("R9 clear bit0", v, 0);
        #1 check("R10 irq drop", int'(irq), 0);

        // R11: stub storage, stub status never set
        to_idle();
        wr(6'h1C, 3);
        wr(6'h28, 31);
        rd(6'h1C, v); check("R11 msalm", v, 3);
        rd(6'h28, v); check("R11 mask", v, 31);
        for (int i = 0; i < 30; i++) begin
            tick();
            rd(6'h2C, v); check("R11 stub status", v & 28, 0);
            #1 check("R11 irq", int'(irq), exp_irq());
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule